// File: doc/BRIEF.md
# Modem Line Change Detector

This block looks after the modem control lines of a serial port. It brings the four incoming status lines (ring indicate, clear to send, carrier detect, data set ready) into the clock domain through a synchronizer and shows their current levels in a status word. The two flow-control-relevant lines, clear to send and carrier detect, each have a change detector. A detected change becomes a pending flag. The pending flags, qualified by their own enables, are ORed into one external-line interrupt request.

Each tracked line has a sense selector. With the selector clear, only the line going high counts as a change. With it set, either direction counts. A read strobe on the status word clears the pending flags, but a change that arrives in the same cycle as the read wins. A second control word holds the request-to-send and data-terminal-ready bits, which reach their pins inverted. It also holds a loopback control bit and the mask bit that gates the summary request toward the enclosing interrupt register.

Software reaches both words through a plain select/strobe port. The read data is combinational, so the status word can be observed without a read strobe, and only `reg_rd` clears the flags.

Top module: `mline_det`

## Requirements
- R1: The synchronized levels of ring indicate, clear to send, carrier detect and data set ready appear in status-word bits 0, 1, 2 and 3 (`reg_sel`=0) two clock edges after the pin changes.
- R2: With its sense bit clear, a tracked line sets its pending flag (status bit 4 for clear to send, bit 5 for carrier detect) on a low-to-high change only; a high-to-low change leaves the flag clear.
- R3: With its sense bit set (status bit 8 for clear to send, bit 9 for carrier detect), a change in either direction sets the pending flag.
- R4: A cycle with `reg_rd`=1 and `reg_sel`=0 clears both pending flags at the next edge. A change detected in that same cycle leaves its flag set.
- R5: `ext_irq` is the OR over both tracked lines of pending flag AND enable (status bit 6 for clear to send, bit 7 for carrier detect). `irq_out` equals `ext_irq` AND the mask bit (control bit 3).
- R6: `dtr_pin` drives the inverse of control bit 0 and `rts_pin` the inverse of control bit 1 (`reg_sel`=1). `loop_en` follows control bit 2.
- R7: After reset, every register bit is 0, both pending flags are clear, `dtr_pin` and `rts_pin` are 1, and both interrupt outputs are 0.
- R8: Writes to the status word change only bits 6 to 9. The level and pending bits ignore written data, and a write does not clear a pending flag.
- R9: A pending flag is recorded whether or not its enable is set. Setting the enable later raises `ext_irq` at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ri_in | input | 1 | Ring indicate line, asynchronous |
| cts_in | input | 1 | Clear to send line, asynchronous |
| dcd_in | input | 1 | Carrier detect line, asynchronous |
| dsr_in | input | 1 | Data set ready line, asynchronous |
| reg_sel | input | 1 | 0 selects status word, 1 selects control word |
| reg_wr | input | 1 | Write strobe for the selected word |
| reg_rd | input | 1 | Read strobe; clears pending flags when status word selected |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected word, combinational |
| dtr_pin | output | 1 | Data terminal ready pin, inverted from control bit |
| rts_pin | output | 1 | Request to send pin, inverted from control bit |
| loop_en | output | 1 | Loopback control |
| ext_irq | output | 1 | OR of enabled pending flags |
| irq_out | output | 1 | Summary request gated by the mask bit |

## Verification
The bench sweeps both tracked lines through every combination of sense bit, enable and mask, in both change directions. A detector that treated every edge as a change, or only rising ones regardless of the sense bit, would leave the wrong flags set. It aims a read strobe at the exact cycle in which a new change is recorded. A design that let the clear win would drop that event, which matters because software would never see it. It also sweeps all sixteen input level patterns and all sixteen control values. These catch swapped level bits, pins that are not inverted, and writes that leak into read-only fields or wipe pending flags.

// File: rtl/mline_pkg.sv
// Package: shared field positions and widths of the modem line detector.
// Assumes a 16-bit register data path; positions are fixed by software use.
package mline_pkg;
    localparam int LINE_CNT = 4;   // ring, cts, dcd, dsr
    localparam int CHG_CNT  = 2;   // tracked lines: cts, dcd
    localparam int DATA_W   = 16;

    typedef enum logic [1:0] {
        LN_RING = 2'd0,
        LN_CTS  = 2'd1,
        LN_DCD  = 2'd2,
        LN_DSR  = 2'd3
    } line_e;

    // status word field bases
    localparam int ST_LVL  = 0;  // 4 level bits
    localparam int ST_PEND = 4;  // 2 pending flags
    localparam int ST_EN   = 6;  // 2 enables
    localparam int ST_NS   = 8;  // 2 either-edge selectors

    // control word bits
    localparam int CT_DTR  = 0;
    localparam int CT_RTS  = 1;
    localparam int CT_LOOP = 2;
    localparam int CT_MASK = 3;
    localparam int CT_W    = 4;
endpackage

// File: rtl/mline_sync.sv
// Module: multi-stage synchronizer for a bus of independent async bits.
// Assumes each bit is independent (no bus coherency needed).
module mline_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // shift the sample one flop deeper each clock
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_q[s] <= '0;
                else if (s == 0)
                    stage_q[s] <= async_in;
                else
                    stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/mline_chg.sv
// Module: change detector and pending flag for one synchronized line.
// Assumes lvl is already synchronous. A set in the clearing cycle wins.
module mline_chg (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic either_edge,
    input  logic clr,
    output logic edge_hit,
    output logic pend
);
    logic prev_q;
    logic pend_q;

    // remember last level for edge compare
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign edge_hit = either_edge ? (lvl ^ prev_q) : (lvl & ~prev_q);

    // pending flag: set by edge, cleared by read, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (edge_hit) pend_q <= 1'b1;
        else if (clr)      pend_q <= 1'b0;
    end

    assign pend = pend_q;
endmodule

// File: rtl/mline_ctl.sv
// Module: output control word; drives inverted handshake pins and loopback.
// Assumes writes are single-cycle strobes.
module mline_ctl
    import mline_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [CT_W-1:0] wdata,
    output logic [CT_W-1:0] word,
    output logic            dtr_pin,
    output logic            rts_pin,
    output logic            loop_en,
    output logic            mask
);
    logic [CT_W-1:0] ctl_q;

    // hold the control word
    always_ff @(posedge clk) begin
        if (!rst_n)  ctl_q <= '0;
        else if (wr) ctl_q <= wdata;
    end

    assign word    = ctl_q;
    assign dtr_pin = ~ctl_q[CT_DTR];
    assign rts_pin = ~ctl_q[CT_RTS];
    assign loop_en = ctl_q[CT_LOOP];
    assign mask    = ctl_q[CT_MASK];
endmodule

// File: rtl/mline_det.sv
// Module: modem line change detector top. Synchronizes four status lines,
// tracks changes on cts and dcd, builds the interrupt summary, and holds
// the output control word. Assumes a simple select/strobe register port.
module mline_det
    import mline_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ri_in,
    input  logic              cts_in,
    input  logic              dcd_in,
    input  logic              dsr_in,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              dtr_pin,
    output logic              rts_pin,
    output logic              loop_en,
    output logic              ext_irq,
    output logic              irq_out
);
    logic [LINE_CNT-1:0] pins;
    logic [LINE_CNT-1:0] lvl;
    logic [CHG_CNT-1:0]  en_q;
    logic [CHG_CNT-1:0]  ns_q;
    logic [CHG_CNT-1:0]  chg_edge;
    logic [CHG_CNT-1:0]  chg_pend;
    logic [CT_W-1:0]     ctl_word;
    logic                mask;
    logic                st_rd;
    logic                st_wr;

    assign pins[LN_RING] = ri_in;
    assign pins[LN_CTS]  = cts_in;
    assign pins[LN_DCD]  = dcd_in;
    assign pins[LN_DSR]  = dsr_in;

    mline_sync #(.WIDTH(LINE_CNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pins), .sync_out(lvl)
    );

    assign st_rd = reg_rd & ~reg_sel;
    assign st_wr = reg_wr & ~reg_sel;

    // writable part of status word: enables and sense selectors
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            ns_q <= '0;
        end else if (st_wr) begin
            en_q <= reg_wdata[ST_EN +: CHG_CNT];
            ns_q <= reg_wdata[ST_NS +: CHG_CNT];
        end
    end

    genvar k;
    generate
        for (k = 0; k < CHG_CNT; k++) begin : g_chg
            mline_chg u_chg (
                .clk(clk), .rst_n(rst_n),
                .lvl(lvl[LN_CTS + k]),
                .either_edge(ns_q[k]),
                .clr(st_rd),
                .edge_hit(chg_edge[k]),
                .pend(chg_pend[k])
            );
        end
    endgenerate

    mline_ctl u_ctl (
        .clk(clk), .rst_n(rst_n),
        .wr(reg_wr & reg_sel),
        .wdata(reg_wdata[CT_W-1:0]),
        .word(ctl_word),
        .dtr_pin(dtr_pin), .rts_pin(rts_pin),
        .loop_en(loop_en), .mask(mask)
    );

    assign ext_irq = |(chg_pend & en_q);
    assign irq_out = ext_irq & mask;

    // assemble read data of the selected word
    always_comb begin
        reg_rdata = '0;
        if (reg_sel) begin
            reg_rdata[CT_W-1:0] = ctl_word;
        end else begin
            reg_rdata[ST_LVL  +: LINE_CNT] = lvl;
            reg_rdata[ST_PEND +: CHG_CNT]  = chg_pend;
            reg_rdata[ST_EN   +: CHG_CNT]  = en_q;
            reg_rdata[ST_NS   +: CHG_CNT]  = ns_q;
        end
    end
endmodule

// File: rtl/mline_det_chk.sv
// Module: assertion checker for mline_det, bound to every instance.
module mline_det_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_sel,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [15:0] reg_wdata,
    input logic        dtr_pin,
    input logic        rts_pin,
    input logic        ext_irq,
    input logic        irq_out,
    input logic [1:0]  chg_edge,
    input logic [1:0]  chg_pend
);
    AST_PIN_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel) |=> (dtr_pin == !$past(reg_wdata[0]) && rts_pin == !$past(reg_wdata[1]))); // R6
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ext_irq); // R5
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        ext_irq |-> (chg_pend != 2'b00)); // R5
    AST_CLR_CTS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_sel && !chg_edge[0]) |=> !chg_pend[0]); // R4
    AST_CLR_DCD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_sel && !chg_edge[1]) |=> !chg_pend[1]); // R4
    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_edge != 2'b00) |=> ((chg_pend & $past(chg_edge)) == $past(chg_edge))); // R4
    AST_SET_ONLY_BY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_pend[0]) |-> $past(chg_edge[0])); // R2
endmodule

bind mline_det mline_det_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .dtr_pin(dtr_pin),
    .rts_pin(rts_pin), .ext_irq(ext_irq), .irq_out(irq_out),
    .chg_edge(chg_edge), .chg_pend(chg_pend)
);

// File: tb/mline_det_tb.sv
// Bench: near-exhaustive sweeps over levels, control word and edge modes.
module mline_det_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ri_in = 0, cts_in = 0, dcd_in = 0, dsr_in = 0;
    logic        reg_sel = 0, reg_wr = 0, reg_rd = 0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        dtr_pin, rts_pin, loop_en, ext_irq, irq_out;
    int          total = 0;
    int          bad = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    mline_det dut_i (
        .clk(clk), .rst_n(rst_n), .ri_in(ri_in), .cts_in(cts_in),
        .dcd_in(dcd_in), .dsr_in(dsr_in), .reg_sel(reg_sel),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dtr_pin(dtr_pin), .rts_pin(rts_pin),
        .loop_en(loop_en), .ext_irq(ext_irq), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        reg_sel = sel; reg_wr = 1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; reg_sel = 0;
    endtask

    task automatic rd_clr();
        reg_sel = 0; reg_rd = 1;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic set_line(input int k, input logic v);
        if (k == 0) cts_in = v; else dcd_in = v;
    endtask

    task automatic peek_status(output logic [15:0] v);
        reg_sel = 0; #0.1; v = reg_rdata;
    endtask

    initial begin
        logic [15:0] v;
        idle(3);
        rst_n = 1;
        @(negedge clk);
        // R7 reset state
        peek_status(v);
        check("R7 status", v, 16'h0);
        check("R7 pins", {14'b0, dtr_pin, rts_pin}, 16'h3);
        check("R7 irq", {14'b0, ext_irq, irq_out}, 16'h0);

        // R1 level sweep
        for (int p = 0; p < 16; p++) begin
            {dsr_in, dcd_in, cts_in, ri_in} = p[3:0];
            idle(4);
            rd_clr();
            peek_status(v);
            check("R1 levels", {12'b0, v[3:0]}, p[15:0]);
        end
        {dsr_in, dcd_in, cts_in, ri_in} = 4'h0;
        idle(4); rd_clr();

        // R6 control sweep
        for (int c = 0; c < 16; c++) begin
            wr(1'b1, c[15:0]);
            check("R6 dtr", {15'b0, dtr_pin}, {15'b0, ~c[0]});
            check("R6 rts", {15'b0, rts_pin}, {15'b0, ~c[1]});
            check("R6 loop", {15'b0, loop_en}, {15'b0, c[2]});
        end

        // R2 R3 R5 R9 edge mode sweep
        for (int k = 0; k < 2; k++)
        for (int ns = 0; ns < 2; ns++)
        for (int en = 0; en < 2; en++)
        for (int mk = 0; mk < 2; mk++) begin
            wr(1'b1, {12'b0, mk[0], 3'b0});
            wr(1'b0, 16'((ns << (8 + k)) | (en << (6 + k))));
            set_line(k, 1'b0); idle(4); rd_clr();
            set_line(k, 1'b1); idle(4);
            peek_status(v);
            check("R2 rise sets", {15'b0, v[4+k]}, 16'h1);
            check("R5 ext_irq", {15'b0, ext_irq}, {15'b0, en[0]});
            check("R5 irq_out", {15'b0, irq_out}, {15'b0, en[0] & mk[0]});
            rd_clr();
            peek_status(v);
            check("R4 read clears", {15'b0, v[4+k]}, 16'h0);
            set_line(k, 1'b0); idle(4);
            peek_status(v);
            check(ns ? "R3 fall sets" : "R2 fall ignored", {15'b0, v[4+k]}, {15'b0, ns[0]});
            if (ns == 1 && en == 0) begin
                // R9 late enable raises irq at once
                wr(1'b0, 16'((1 << (8 + k)) | (1 << (6 + k))));
                check("R9 late enable", {15'b0, ext_irq}, 16'h1);
            end
            rd_clr();
        end

        // R8 write to read-only bits ignored, pending kept
        wr(1'b0, 16'h0);
        cts_in = 1; idle(4);
        wr(1'b0, 16'h003F);
        peek_status(v);
        check("R8 ro bits", v, 16'h0012);
        rd_clr(); cts_in = 0; idle(4); rd_clr();

        // R4 edge coinciding with clearing read
        wr(1'b0, 16'h0);
        dcd_in = 1;          // change before edge P1
        idle(2);             // past P1, P2
        reg_sel = 0; reg_rd = 1;
        @(negedge clk);      // read active at P3 when edge is recorded
        reg_rd = 0;
        peek_status(v);
        check("R4 edge beats clear", {15'b0, v[5]}, 16'h1);
        rd_clr();
        peek_status(v);
        check("R4 later clear", {15'b0, v[5]}, 16'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule